// File: doc/BRIEF.md
# Data-Selected Transfer Sequence Dispatcher

This block sits in front of a descriptor-driven transfer engine and adds sequence transfer to it. One trigger input is assigned to sequence transfer. When a trigger arrives while no sequence is paused, the dispatcher first fetches one data word from a configured address. The low eight bits of that word select one of 256 entries in a pointer table. The chosen entry gives the address of a list of step words. The dispatcher walks that list and hands each step's descriptor address to the transfer engine. It waits for the engine to finish each step before it fetches the next one.

A step word carries two flags besides its descriptor address. The end flag closes the sequence. The split flag pauses the sequence after the current step. A paused sequence keeps its list pointer and its step index. The next trigger then goes straight back to the step list and skips the selection fetches. A step may describe any kind of transfer the engine supports, including normal, repeat, block and chained transfers, because the dispatcher only forwards the descriptor address.

Top module: `seqDispatch`

## Requirements
- R1: After reset the block is idle: `busy`, `memReq`, `xferStart` and `seqDone` are all low.
- R2: A trigger taken while idle and not paused begins with a single memory read at `cfgDataAddr`.
- R3: The second read of a fresh run is at `cfgTableBase + 4*s`, where s is bits [7:0] of the fetched data word. Bits [31:8] of that word have no effect. The word read there is the list pointer P.
- R4: Step i is read from `P + 4*i`, counting from i = 0. In a step word, bit 31 is the end flag, bit 30 is the split flag, and bits [29:0] are the descriptor address. The descriptor address is driven on `xferDesc` with bits [31:30] zero, together with a one-cycle `xferStart` pulse.
- R5: After each `xferStart`, no memory read is issued until `xferDone` is seen.
- R6: When a step with the end flag set completes, `seqDone` pulses for exactly one cycle and the block returns to idle. The end flag wins over the split flag. The paused state is cleared, so the next trigger starts a fresh run.
- R7: When a step with the split flag set and the end flag clear completes, the block goes idle without `seqDone`. The next trigger issues no data or table read. It continues with step i+1 of the same list.
- R8: Triggers that arrive while `busy` is high have no effect on the run.
- R9: `memAddr` holds steady while `memReq` is high and `memRdValid` is low. `memReq` and `xferStart` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | Request from the assigned trigger source |
| cfgDataAddr | input | 32 | Address of the selection data word |
| cfgTableBase | input | 32 | Base address of the 256-entry pointer table |
| memReq | output | 1 | Read request, held until `memRdValid` |
| memAddr | output | 32 | Read address |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 32 | Read data |
| xferStart | output | 1 | One-cycle start to the transfer engine |
| xferDesc | output | 32 | Descriptor address for the engine |
| xferDone | input | 1 | Engine finished the current step |
| seqDone | output | 1 | One-cycle pulse when a sequence ends |
| busy | output | 1 | A run is in progress |

## Verification
The checker watches, on every cycle, the properties of the handshakes. It checks that `xferStart` lasts one cycle and never overlaps a read request. It checks that the read address holds while a request waits. It checks that `seqDone` only appears as the block goes idle, and that an idle trigger always starts a run. Several behaviours depend on memory contents and on history across triggers, so only the bench scenarios can show them. These are the table address formed from the selection value, the order and contents of the descriptors, the resume that skips both selection reads, the clearing of the paused state after an end step, and the rejection of triggers during a run. The bench sweeps all 256 selection values, with noise in the upper data bits, over eight sequence shapes.

// File: rtl/seqPkg.sv
package seqPkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RDDATA, ST_RDPTR, ST_RDSTEP, ST_ISSUE, ST_WAIT
  } stateT;

  typedef enum logic [1:0] {ADDR_DATA, ADDR_TABLE, ADDR_STEP} addrSelT;

  typedef struct packed {
    logic    loadSel;
    logic    loadPtr;
    logic    loadStep;
    logic    clrIdx;
    logic    incIdx;
    logic    setSusp;
    logic    clrSusp;
    addrSelT addrSel;
  } dpStrobeT;
endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import seqPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     trigIn,
  input  logic     memRdValid,
  input  logic     xferDone,
  input  logic     endFlag,
  input  logic     splitFlag,
  input  logic     suspended,
  output dpStrobeT strobe,
  output logic     memReq,
  output logic     xferStart,
  output logic     seqDone,
  output logic     busy
);
  stateT state, stateNext;
  logic  doneNext;

  always_comb begin
    stateNext = state;
    doneNext  = 1'b0;
    strobe    = '0;
    strobe.addrSel = ADDR_STEP;
    case (state)
      ST_IDLE: if (trigIn) begin
        if (suspended) begin
          strobe.clrSusp = 1'b1;
          stateNext = ST_RDSTEP;
        end else begin
          strobe.clrIdx = 1'b1;
          stateNext = ST_RDDATA;
        end
      end
      ST_RDDATA: begin
        strobe.addrSel = ADDR_DATA;
        if (memRdValid) begin
          strobe.loadSel = 1'b1;
          stateNext = ST_RDPTR;
        end
      end
      ST_RDPTR: begin
        strobe.addrSel = ADDR_TABLE;
        if (memRdValid) begin
          strobe.loadPtr = 1'b1;
          stateNext = ST_RDSTEP;
        end
      end
      ST_RDSTEP: if (memRdValid) begin
        strobe.loadStep = 1'b1;
        stateNext = ST_ISSUE;
      end
      ST_ISSUE: stateNext = ST_WAIT;
      ST_WAIT: if (xferDone) begin
        if (endFlag) begin
          strobe.clrIdx  = 1'b1;
          strobe.clrSusp = 1'b1;
          doneNext  = 1'b1;
          stateNext = ST_IDLE;
        end else if (splitFlag) begin
          strobe.incIdx  = 1'b1;
          strobe.setSusp = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          strobe.incIdx = 1'b1;
          stateNext = ST_RDSTEP;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      seqDone <= 1'b0;
    end else begin
      state   <= stateNext;
      seqDone <= doneNext;
    end
  end

  assign memReq    = (state == ST_RDDATA) || (state == ST_RDPTR) || (state == ST_RDSTEP);
  assign xferStart = (state == ST_ISSUE);
  assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int SEL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic [ADDR_W-1:0] cfgDataAddr,
  input  logic [ADDR_W-1:0] cfgTableBase,
  input  logic [ADDR_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] xferDesc,
  output logic              endFlag,
  output logic              splitFlag,
  output logic              suspended
);
  localparam int DESC_W = ADDR_W - 2;

  logic [SEL_W-1:0]  selVal;
  logic [ADDR_W-1:0] seqPtr;
  logic [ADDR_W-1:0] stepWord;
  logic [IDX_W-1:0]  stepIdx;
  logic [ADDR_W-1:0] tableAddr, stepAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selVal    <= '0;
      seqPtr    <= '0;
      stepWord  <= '0;
      stepIdx   <= '0;
      suspended <= 1'b0;
    end else begin
      if (strobe.loadSel)  selVal   <= memRdData[SEL_W-1:0];
      if (strobe.loadPtr)  seqPtr   <= memRdData;
      if (strobe.loadStep) stepWord <= memRdData;
      if (strobe.clrIdx)       stepIdx <= '0;
      else if (strobe.incIdx)  stepIdx <= stepIdx + 1'b1;
      if (strobe.setSusp)      suspended <= 1'b1;
      else if (strobe.clrSusp) suspended <= 1'b0;
    end
  end

  assign tableAddr = cfgTableBase + {{(ADDR_W-SEL_W-2){1'b0}}, selVal, 2'b00};
  assign stepAddr  = seqPtr + {{(ADDR_W-IDX_W-2){1'b0}}, stepIdx, 2'b00};

  always_comb begin
    case (strobe.addrSel)
      ADDR_DATA:  memAddr = cfgDataAddr;
      ADDR_TABLE: memAddr = tableAddr;
      default:    memAddr = stepAddr;
    endcase
  end

  assign xferDesc  = {2'b00, stepWord[DESC_W-1:0]};
  assign endFlag   = stepWord[ADDR_W-1];
  assign splitFlag = stepWord[ADDR_W-2];
endmodule

// File: rtl/seqDispatch.sv
module seqDispatch
  import seqPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int SEL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigIn,
  input  logic [ADDR_W-1:0] cfgDataAddr,
  input  logic [ADDR_W-1:0] cfgTableBase,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRdValid,
  input  logic [ADDR_W-1:0] memRdData,
  output logic              xferStart,
  output logic [ADDR_W-1:0] xferDesc,
  input  logic              xferDone,
  output logic              seqDone,
  output logic              busy
);
  dpStrobeT strobe;
  logic     endFlag, splitFlag, suspended;

  seqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .memRdValid(memRdValid),
    .xferDone(xferDone), .endFlag(endFlag), .splitFlag(splitFlag),
    .suspended(suspended), .strobe(strobe), .memReq(memReq),
    .xferStart(xferStart), .seqDone(seqDone), .busy(busy)
  );

  seqDatapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEL_W(SEL_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgDataAddr(cfgDataAddr),
    .cfgTableBase(cfgTableBase), .memRdData(memRdData), .memAddr(memAddr),
    .xferDesc(xferDesc), .endFlag(endFlag), .splitFlag(splitFlag),
    .suspended(suspended)
  );
endmodule

// File: rtl/seqDispatchChk.sv
module seqDispatchChk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              trigIn,
  input logic              busy,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdValid,
  input logic              xferStart,
  input logic              seqDone
);
  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart);

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && xferStart));

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRdValid) |=> (memReq && $stable(memAddr)));

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> !busy);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);

  assert_trig_starts_R2: assert property (@(posedge clk) disable iff (!rstN)
    (trigIn && !busy) |=> busy);
endmodule

bind seqDispatch seqDispatchChk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .trigIn(trigIn), .busy(busy), .memReq(memReq),
  .memAddr(memAddr), .memRdValid(memRdValid), .xferStart(xferStart),
  .seqDone(seqDone)
);

// File: tb/seqDispatch_test.sv
module seqDispatch_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DATA_ADDR  = 32'h0000_0000;
  localparam logic [31:0] TABLE_BASE = 32'h0000_0400;
  localparam logic [31:0] SEQ_BASE   = 32'h0000_0800;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigIn = 1'b0;
  logic memReq, memRdValid, xferStart, xferDone, seqDone, busy;
  logic [31:0] memAddr, memRdData, xferDesc;

  logic [31:0] mem [0:1023];
  logic [1:0]  doneSh;
  logic        engPending;

  int errors = 0;
  int checks = 0;
  int startCnt, doneCnt, dataReads, tableReads, readsDuringXfer;
  logic [31:0] lastTableAddr;
  logic [31:0] descLog [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  seqDispatch uut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .cfgDataAddr(DATA_ADDR),
    .cfgTableBase(TABLE_BASE), .memReq(memReq), .memAddr(memAddr),
    .memRdValid(memRdValid), .memRdData(memRdData), .xferStart(xferStart),
    .xferDesc(xferDesc), .xferDone(xferDone), .seqDone(seqDone), .busy(busy)
  );

  // memory with one cycle latency, transfer engine finishing two cycles after start
  always @(posedge clk) begin
    if (!rstN) begin
      memRdValid <= 1'b0;
      memRdData  <= '0;
      doneSh     <= '0;
    end else begin
      memRdValid <= memReq && !memRdValid;
      memRdData  <= mem[memAddr[11:2]];
      doneSh     <= {doneSh[0], xferStart};
    end
  end
  assign xferDone = doneSh[1];

  // monitor
  always @(posedge clk) begin
    if (rstN) begin
      if (xferStart) begin
        if (startCnt < 8) descLog[startCnt] <= xferDesc;
        startCnt <= startCnt + 1;
        engPending <= 1'b1;
      end else if (xferDone) engPending <= 1'b0;
      if (seqDone) doneCnt <= doneCnt + 1;
      if (memReq && engPending) readsDuringXfer <= readsDuringXfer + 1;
      if (memReq && memRdValid && memAddr == DATA_ADDR) dataReads <= dataReads + 1;
      if (memReq && memRdValid && memAddr >= TABLE_BASE && memAddr < SEQ_BASE) begin
        tableReads <= tableReads + 1;
        lastTableAddr <= memAddr;
      end
    end else engPending <= 1'b0;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearLog();
    @(negedge clk);
    startCnt = 0; doneCnt = 0; dataReads = 0; tableReads = 0;
    readsDuringXfer = 0; lastTableAddr = '0;
  endtask

  function automatic int seqLen(input int k);
    return (k % 4) + 1;
  endfunction

  function automatic logic [31:0] descOf(input int k, input int j);
    return 32'h0010_0000 + k*256 + j*16;
  endfunction

  task automatic runTrig(input logic extra);
    int guard;
    @(negedge clk) trigIn = 1'b1;
    @(negedge clk) trigIn = 1'b0;
    if (extra) begin
      repeat (3) @(negedge clk);
      trigIn = 1'b1;
      @(negedge clk) trigIn = 1'b0;
    end
    guard = 0;
    while (busy && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int w = 0; w < 1024; w++) mem[w] = '0;
    for (int v = 0; v < 256; v++) mem[256 + v] = SEQ_BASE + 32'h40 * (v % 8);
    for (int k = 0; k < 8; k++) begin
      for (int j = 0; j < seqLen(k); j++) begin
        logic endF, splitF;
        endF   = (j == seqLen(k) - 1);
        splitF = (k >= 4) && (j == 0);
        mem[512 + 16*k + j] = {endF, splitF, descOf(k, j)[29:0]};
      end
    end
    startCnt = 0; doneCnt = 0; dataReads = 0; tableReads = 0; readsDuringXfer = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !memReq && !xferStart && !seqDone, "R1 reset idle",
        {28'b0, busy, memReq, xferStart, seqDone}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !memReq && !xferStart && !seqDone, "R1 idle after reset",
        {28'b0, busy, memReq, xferStart, seqDone}, 32'h0);

    for (int v = 0; v < 256; v++) begin
      int k, len, first;
      logic extra;
      k = v % 8;
      len = seqLen(k);
      extra = (v % 37 == 3);
      mem[0] = {8'hC3, 8'(v * 7 + 1), 8'h5A, 8'(v)};
      clearLog();
      runTrig(extra);
      chk(dataReads == 1, "R2 data read on fresh trigger", dataReads, 1);
      chk(tableReads == 1 && lastTableAddr == TABLE_BASE + 4*v,
          "R3 table address from low byte", lastTableAddr, TABLE_BASE + 4*v);
      first = (k >= 5) ? 1 : len;
      chk(startCnt == first, extra ? "R8 extra trigger ignored" : "R4 step count",
          startCnt, first);
      for (int j = 0; j < first; j++)
        chk(descLog[j] == descOf(k, j), "R4 descriptor", descLog[j], descOf(k, j));
      chk(readsDuringXfer == 0, "R5 no read while engine busy", readsDuringXfer, 0);
      if (k >= 5) begin
        chk(doneCnt == 0, "R7 no done at split", doneCnt, 0);
        mem[0] = {24'hFFFF00, 8'(v + 3)};
        clearLog();
        runTrig(1'b0);
        chk(dataReads == 0 && tableReads == 0, "R7 resume skips selection",
            dataReads + tableReads, 0);
        chk(startCnt == len - 1, "R7 resumed step count", startCnt, len - 1);
        for (int j = 1; j < len; j++)
          chk(descLog[j-1] == descOf(k, j), "R7 resumed descriptor",
              descLog[j-1], descOf(k, j));
        chk(doneCnt == 1, "R6 single done pulse after resume", doneCnt, 1);
      end else begin
        chk(doneCnt == 1, "R6 single done pulse", doneCnt, 1);
      end
      chk(!busy, "R6 idle at end", {31'b0, busy}, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule